// File: doc/BRIEF.md
# Enabled Repeating Digit Sequencer

This block is a small synchronous Moore machine that repeatedly walks through four fixed decimal digits: 4, then 6, then 9, then 1, and then back to 4. Each digit appears on the output as a 4-bit BCD code. The state lives in a 2-bit register made only of D-type flops. One combinational block computes the next state and a separate combinational block decodes the present state into the digit.

A high enable lets the machine move forward one state on every rising clock edge. A low enable holds both the state and the digit where they are. A synchronous active-high reset returns the machine to its first state, so the digit reads 4 after reset. The state register is also driven out as a port, so the position in the sequence can be watched directly.

Top module: `digit_seq_top`

## Requirements
- R1: A rising clock edge with `rst` high puts `state` at 2'b00 and `digit` at 4'b0100 (decimal 4).
- R2: A rising clock edge with `rst` low and `en` high moves `state` forward by one: 00 to 01, 01 to 10, 10 to 11, and 11 back to 00.
- R3: A rising clock edge with `rst` low and `en` low leaves both `state` and `digit` unchanged.
- R4: `digit` depends only on `state`, using this BCD map: 00 gives 0100, 01 gives 0110, 10 gives 1001, and 11 gives 0001. No other code ever appears, so `digit` never goes above 9.
- R5: Changing `en` between clock edges has no effect on `digit`. `digit` changes only when `state` changes at a clock edge.
- R6: With `en` held high for more than four edges, `digit` repeats the pattern 4, 6, 9, 1 with a period of four edges.
- R7: Reset wins over enable. With `rst` and `en` both high, the machine goes to state 00 from any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; a low level holds the sequence |
| digit | output | 4 | BCD code of the present digit |
| state | output | 2 | Present state register; the upper bit is the more significant state variable |

## Verification
The bench drives every pairing of present state and enable, one edge at a time, and compares each result with the transition table. A swapped state code or a broken wrap from 11 back to 00 shows up there as the wrong next digit. Long enabled runs check that the pattern repeats with a period of four. A design that skipped or doubled a state would drift away from the expected period.

Enable is held low in the middle of the sequence, and a design that leaks enable into the next state would drift during that hold. Enable is also toggled between clock edges, which exposes output logic that reads enable directly instead of only the registered state. Reset is applied with enable high and from the last state, which exposes a reset that loses to enable or lands on a non-zero code.

// File: rtl/digit_seq_pkg.sv
package digit_seq_pkg;
   localparam int SEQ_STATE_W = 2;

   typedef enum logic [SEQ_STATE_W-1:0] {
      SEQ_S0 = 2'b00,
      SEQ_S1 = 2'b01,
      SEQ_S2 = 2'b10,
      SEQ_S3 = 2'b11
   } seq_state_e;

   localparam int NEXT_EQN = 0;   // hand-reduced flop equations
   localparam int NEXT_ADD = 1;   // incrementer form
endpackage

// File: rtl/digit_seq_dreg.sv
// Bank of D flops with synchronous reset; one flop per bit via generate.
module digit_seq_dreg #(
   parameter int                W       = 2,
   parameter logic [W-1:0]      RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("digit_seq_dreg: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst) q[b] <= RST_VAL[b];
         else     q[b] <= d[b];
      end
   end
endmodule

// File: rtl/digit_seq_next.sv
// Next-state logic: the D inputs for the state flops.
module digit_seq_next #(
   parameter int STATE_W = 2,
   parameter int STYLE   = digit_seq_pkg::NEXT_EQN
) (
   input  logic [STATE_W-1:0] q,
   input  logic               en,
   output logic [STATE_W-1:0] d
);
   if (STYLE != digit_seq_pkg::NEXT_EQN && STYLE != digit_seq_pkg::NEXT_ADD) begin : g_bad_style
      $error("digit_seq_next: unknown STYLE");
   end

   if (STYLE == digit_seq_pkg::NEXT_EQN) begin : g_eqn
      if (STATE_W != 2) begin : g_bad_w
         $error("digit_seq_next: equation form needs STATE_W == 2");
      end
      always_comb begin
         d    = q;
         d[1] = q[1] ^ (q[0] & en);
         d[0] = q[0] ^ en;
      end
   end else begin : g_add
      always_comb begin
         d = q + STATE_W'(en);
      end
   end
endmodule

// File: rtl/digit_seq_decode.sv
// Moore output logic: present state to BCD digit.
module digit_seq_decode
   import digit_seq_pkg::*;
#(
   parameter int DIGIT_W = 4,
   parameter int DIG0    = 4,
   parameter int DIG1    = 6,
   parameter int DIG2    = 9,
   parameter int DIG3    = 1
) (
   input  logic [SEQ_STATE_W-1:0] state,
   output logic [DIGIT_W-1:0]     digit
);
   localparam logic [DIGIT_W-1:0] V0 = DIGIT_W'(DIG0);
   localparam logic [DIGIT_W-1:0] V1 = DIGIT_W'(DIG1);
   localparam logic [DIGIT_W-1:0] V2 = DIGIT_W'(DIG2);
   localparam logic [DIGIT_W-1:0] V3 = DIGIT_W'(DIG3);

   seq_state_e cur;
   assign cur = seq_state_e'(state);

   always_comb begin
      unique case (cur)
         SEQ_S0:  digit = V0;
         SEQ_S1:  digit = V1;
         SEQ_S2:  digit = V2;
         SEQ_S3:  digit = V3;
         default: digit = V0;
      endcase
   end
endmodule

// File: rtl/digit_seq_top.sv
module digit_seq_top
   import digit_seq_pkg::*;
#(
   parameter int DIGIT_W    = 4,
   parameter int DIG0       = 4,
   parameter int DIG1       = 6,
   parameter int DIG2       = 9,
   parameter int DIG3       = 1,
   parameter int NEXT_STYLE = NEXT_EQN
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   en,
   output logic [DIGIT_W-1:0]     digit,
   output logic [SEQ_STATE_W-1:0] state
);
   localparam int MAX_DIG = 9;

   if (DIGIT_W < 4) begin : g_bad_width
      $error("digit_seq_top: DIGIT_W too narrow for BCD");
   end
   if (DIG0 < 0 || DIG0 > MAX_DIG || DIG1 < 0 || DIG1 > MAX_DIG ||
       DIG2 < 0 || DIG2 > MAX_DIG || DIG3 < 0 || DIG3 > MAX_DIG) begin : g_bad_digit
      $error("digit_seq_top: each digit must be 0..9");
   end

   logic [SEQ_STATE_W-1:0] q_now;
   logic [SEQ_STATE_W-1:0] d_next;

   digit_seq_next #(
      .STATE_W (SEQ_STATE_W),
      .STYLE   (NEXT_STYLE)
   ) next_i (
      .q  (q_now),
      .en (en),
      .d  (d_next)
   );

   digit_seq_dreg #(
      .W       (SEQ_STATE_W),
      .RST_VAL (SEQ_S0)
   ) state_i (
      .clk (clk),
      .rst (rst),
      .d   (d_next),
      .q   (q_now)
   );

   digit_seq_decode #(
      .DIGIT_W (DIGIT_W),
      .DIG0    (DIG0),
      .DIG1    (DIG1),
      .DIG2    (DIG2),
      .DIG3    (DIG3)
   ) dec_i (
      .state (q_now),
      .digit (digit)
   );

   assign state = q_now;
endmodule

// File: rtl/digit_seq_chk.sv
module digit_seq_chk #(
   parameter int DIGIT_W = 4,
   parameter int DIG0    = 4,
   parameter int STATE_W = 2
) (
   input logic               clk,
   input logic               rst,
   input logic               en,
   input logic [DIGIT_W-1:0] digit,
   input logic [STATE_W-1:0] state
);
   assert_reset_to_s0_R1: assert property (@(posedge clk)
      rst |=> (state == '0 && digit == DIGIT_W'(DIG0)));

   assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
      en |=> state == STATE_W'($past(state) + 1'b1));

   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(state) && $stable(digit)));

   assert_bcd_range_R4: assert property (@(posedge clk) disable iff (rst)
      digit <= DIGIT_W'(9));

   assert_digit_follows_state_R5: assert property (@(posedge clk) disable iff (rst)
      $stable(state) |-> $stable(digit));
endmodule

bind digit_seq_top digit_seq_chk #(
   .DIGIT_W (DIGIT_W),
   .DIG0    (DIG0),
   .STATE_W (digit_seq_pkg::SEQ_STATE_W)
) chk_i (
   .clk   (clk),
   .rst   (rst),
   .en    (en),
   .digit (digit),
   .state (state)
);

// File: tb/digit_seq_top_tb_top.sv
`timescale 1ns/1ps
module digit_seq_top_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic [3:0] digit;
   logic [1:0] state;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   digit_seq_top dut_i (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .digit (digit),
      .state (state)
   );

   function automatic logic [3:0] exp_digit(input logic [1:0] s);
      case (s)
         2'b00:   return 4'b0100;
         2'b01:   return 4'b0110;
         2'b10:   return 4'b1001;
         default: return 4'b0001;
      endcase
   endfunction

   // One rising edge, then settle 1 ns past it before anything is read or driven.
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [1:0] s_exp);
      n_checks++;
      if (state !== s_exp || digit !== exp_digit(s_exp)) begin
         n_errors++;
         $display("FAIL %s: state=%b digit=%b expected state=%b digit=%b",
                  req, state, digit, s_exp, exp_digit(s_exp));
      end
   endtask

   task automatic go_to(input logic [1:0] s);
      rst = 1'b1; en = 1'b0;
      step();
      rst = 1'b0; en = 1'b1;
      for (int i = 0; i < int'(s); i++) step();
      en = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1; en = 1'b1;
      step();
      step();
      check("R1 reset state (R7 enable high)", 2'b00);
      rst = 1'b0; en = 1'b0;
   endtask

   task automatic t_table();
      for (int s = 0; s < 4; s++) begin
         for (int e = 0; e < 2; e++) begin
            go_to(2'(s));
            check("R4 reached state", 2'(s));
            en = e[0];
            step();
            en = 1'b0;
            if (e == 1) check("R2 advance from state", 2'(s + 1));
            else        check("R3 hold at state", 2'(s));
         end
      end
   endtask

   task automatic t_long_run();
      go_to(2'b00);
      en = 1'b1;
      for (int i = 1; i <= 10; i++) begin
         step();
         check("R6 repeating pattern", 2'(i));
      end
      en = 1'b0;
   endtask

   task automatic t_hold_mid();
      go_to(2'b10);
      for (int i = 0; i < 5; i++) begin
         step();
         check("R3 frozen mid-sequence", 2'b10);
      end
      en = 1'b1;
      step();
      en = 1'b0;
      check("R2 resume after hold", 2'b11);
   endtask

   task automatic t_en_between_edges();
      go_to(2'b01);
      for (int i = 0; i < 4; i++) begin
         en = ~en;
         #0.5;
         check("R5 digit ignores enable between edges", 2'b01);
      end
      en = 1'b0;
   endtask

   task automatic t_reset_priority();
      go_to(2'b11);
      rst = 1'b1; en = 1'b1;
      step();
      check("R7 reset beats enable from S3", 2'b00);
      rst = 1'b0; en = 1'b0;
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   initial begin
      #1;
      t_reset();
      t_table();
      t_long_run();
      t_hold_mid();
      t_en_between_edges();
      t_reset_priority();
      report();
   end

   initial begin
      #(5.0 * 200000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      report();
   end
endmodule